// File: doc/BRIEF.md
# Dual Up/Down Timer with Capture/Reload

This block holds two 16-bit up/down timers and one capture/reload register. The core timer counts either on a tick from a shared power-of-two prescaler or on rising edges of an external count pin. The core timer's count direction comes from a control bit, and an external direction pin can flip it. Each time the core timer wraps, a toggle latch inverts and drives an output pin. If reload is enabled, the wrap also loads the core timer from the capture/reload register.

The auxiliary timer has the same direction logic. It can count prescaled ticks, rising edges of its own pin, or transitions of the core timer's toggle latch. Counting the latch transitions chains the two timers into one long counter. A selected edge on the capture pin copies the auxiliary timer into the capture/reload register and can clear the auxiliary timer. Software programs the unit through a write-enable/address bus with a combinational read port. Wraps and captures each raise a one-cycle interrupt pulse. Every external pin passes through a two-flop synchronizer before any edge is detected.

Register addresses: 0 is core control, 1 is auxiliary control, 2 is the core count, 3 is the auxiliary count and 4 is capture/reload. Any other address reads as zero.

Top module: `gp_dual_timer`

## Requirements
- R1: After reset, all five registers read 0, and `tgl_o` and all three interrupt outputs are low.
- R2: Core control bits [7:4] and auxiliary control bits [8:5] hold a prescale exponent n. The value is clamped to the range 2..12. With the prescaled source selected and the timer running (control bit 0), the timer steps exactly once every 2^n clocks. No prescaled tick is ever followed by another tick in the next cycle. A timer that is not running holds its value.
- R3: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Each wrap raises that timer's interrupt for exactly one cycle.
- R4: Control bit 1 selects down counting. When control bit 2 is set, a high level on the synchronized direction pin inverts the direction chosen by bit 1.
- R5: Core control bit 3 selects the external source. The core timer then steps once per rising edge of the synchronized `core_cnt_i`.
- R6: `tgl_o` inverts on every core-timer wrap, whether the wrap is an overflow or an underflow.
- R7: When auxiliary control bits [4:3] = 2, the auxiliary timer steps once per transition of the toggle latch. The other values of bits [4:3] select: 0 for prescaled, 1 for `aux_cnt_i` rising edges, 3 for no source.
- R8: When core control bit 8 is set, a core-timer wrap loads the core timer from the capture/reload register instead of the wrap value.
- R9: Auxiliary control bit 9 enables capture. Bits [11:10] select the capture edge: 01 for rising, 10 for falling, 11 for both. When the selected edge arrives on the synchronized `cap_i`, the auxiliary timer value is copied into capture/reload and `cap_irq_o` pulses. If bit 12 is also set, the auxiliary timer is cleared.
- R10: If a capture and a software write to capture/reload fall in the same cycle, the captured value is stored.
- R11: While capture is disabled, or on an edge that is not selected, edges on `cap_i` leave both capture/reload and the auxiliary timer unchanged.
- R12: A software write to a count register takes precedence over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| core_cnt_i | input | 1 | External count pin of the core timer |
| core_dir_i | input | 1 | External direction pin of the core timer |
| aux_cnt_i | input | 1 | External count pin of the auxiliary timer |
| aux_dir_i | input | 1 | External direction pin of the auxiliary timer |
| cap_i | input | 1 | Capture trigger pin |
| tgl_o | output | 1 | Core-timer toggle latch |
| core_irq_o | output | 1 | Core-timer wrap pulse |
| aux_irq_o | output | 1 | Auxiliary-timer wrap pulse |
| cap_irq_o | output | 1 | Capture pulse |

## Verification
A corrupted count shows up on the read port as soon as a count register is read back, which is one sample after the offending step. A wrong toggle latch or reload shows at `tgl_o`, and in the reloaded value, on the clock after the wrap. A mistake in synchronizer depth or edge selection shifts a capture or a count by whole cycles. The bench exposes this by lining a software write up against the expected edge cycle, so a slip of a single cycle changes the value that is read back. Errors in the prescaler appear as a wrong interval between successive count changes, measured in clocks.

// File: rtl/dt_pkg.sv
package dt_pkg;

  localparam int CTRL_W = 16;

  localparam int A_CORE_CTL = 0;
  localparam int A_AUX_CTL  = 1;
  localparam int A_CORE_CNT = 2;
  localparam int A_AUX_CNT  = 3;
  localparam int A_CAPREL   = 4;

  typedef enum logic [1:0] {
    AUX_PRESC = 2'd0,
    AUX_EXT   = 2'd1,
    AUX_CHAIN = 2'd2,
    AUX_OFF   = 2'd3
  } aux_src_e;

  typedef struct packed {
    logic [6:0] rsvd;
    logic       reload_en;
    logic [3:0] n;
    logic       src_ext;
    logic       ext_dir;
    logic       down;
    logic       run;
  } core_ctrl_t;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       clr_cap;
    logic [1:0] cap_edge;
    logic       cap_en;
    logic [3:0] n;
    aux_src_e   src;
    logic       ext_dir;
    logic       down;
    logic       run;
  } aux_ctrl_t;

endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int PRE_W = 12,
  parameter int NUM   = 2,
  parameter int N_MIN = 2,
  parameter int N_MAX = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM-1:0][3:0] n_i,
  output logic [NUM-1:0]      tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_sel
    logic [3:0]       n_c;
    logic [PRE_W-1:0] mask;
    always_comb begin
      if (int'(n_i[i]) < N_MIN)      n_c = 4'(N_MIN);
      else if (int'(n_i[i]) > N_MAX) n_c = 4'(N_MAX);
      else                           n_c = n_i[i];
      mask = (PRE_W'(1) << n_c) - 1'b1;
    end
    assign tick_o[i] = ((pre_q & mask) == mask);

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[i] |=> !tick_o[i]); // R2
  end
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         down_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         reload_en_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         step, at_lim;

  assign at_lim = down_i ? (cnt_q == '0) : (cnt_q == '1);
  assign step   = run_i && tick_i && !load_en_i && !clr_i;
  assign wrap_o = step && at_lim;
  assign cnt_o  = cnt_q;

  // priority: software load, clear, reload on wrap, step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_en_i)              cnt_q <= load_val_i;
    else if (clr_i)                  cnt_q <= '0;
    else if (wrap_o && reload_en_i)  cnt_q <= reload_val_i;
    else if (step)                   cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !down_i && !reload_en_i) |=> (cnt_o == '0)); // R3
  AST_WRAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && down_i && !reload_en_i) |=> (cnt_o == '1)); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && reload_en_i) |=> (cnt_o == $past(reload_val_i))); // R8
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> (cnt_o == $past(load_val_i))); // R12
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !clr_i && !(run_i && tick_i)) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/gp_dual_timer.sv
module gp_dual_timer
  import dt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int PRE_W       = 12,
  parameter int N_MIN       = 2,
  parameter int N_MAX       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              core_cnt_i,
  input  logic              core_dir_i,
  input  logic              aux_cnt_i,
  input  logic              aux_dir_i,
  input  logic              cap_i,
  output logic              tgl_o,
  output logic              core_irq_o,
  output logic              aux_irq_o,
  output logic              cap_irq_o
);
  localparam int NT   = 2;
  localparam int NPIN = 5;

  core_ctrl_t core_ctrl_q;
  aux_ctrl_t  aux_ctrl_q;
  logic [CNT_W-1:0] cr_q;

  logic wr_core_ctl, wr_aux_ctl, wr_cr;
  assign wr_core_ctl = wr_en_i && (addr_i == ADDR_W'(A_CORE_CTL));
  assign wr_aux_ctl  = wr_en_i && (addr_i == ADDR_W'(A_AUX_CTL));
  assign wr_cr       = wr_en_i && (addr_i == ADDR_W'(A_CAPREL));

  // pin synchronisation: {cap, aux_dir, aux_cnt, core_dir, core_cnt}
  logic [NPIN-1:0] pin_s;
  dt_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cap_i, aux_dir_i, aux_cnt_i, core_dir_i, core_cnt_i}),
    .q_o(pin_s)
  );

  logic [2:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= {pin_s[4], pin_s[2], pin_s[0]};
  end

  logic core_rise, aux_rise, cap_rise, cap_fall;
  assign core_rise = pin_s[0] && !prev_q[0];
  assign aux_rise  = pin_s[2] && !prev_q[1];
  assign cap_rise  = pin_s[4] && !prev_q[2];
  assign cap_fall  = !pin_s[4] && prev_q[2];

  logic [NT-1:0] psc_tick;
  dt_prescaler #(.PRE_W(PRE_W), .NUM(NT), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_psc (
    .clk_i, .rst_ni,
    .n_i({aux_ctrl_q.n, core_ctrl_q.n}),
    .tick_o(psc_tick)
  );

  logic [NT-1:0]            run, tick, down, load, clr, rld_en, wrap;
  logic [NT-1:0][CNT_W-1:0] rld_val, cnt;
  logic                     cap_evt;

  assign cap_evt = aux_ctrl_q.cap_en &&
                   ((aux_ctrl_q.cap_edge[0] && cap_rise) ||
                    (aux_ctrl_q.cap_edge[1] && cap_fall));

  always_comb begin
    run[0]     = core_ctrl_q.run;
    tick[0]    = core_ctrl_q.src_ext ? core_rise : psc_tick[0];
    down[0]    = core_ctrl_q.down ^ (core_ctrl_q.ext_dir && pin_s[1]);
    load[0]    = wr_en_i && (addr_i == ADDR_W'(A_CORE_CNT));
    clr[0]     = 1'b0;
    rld_en[0]  = core_ctrl_q.reload_en;
    rld_val[0] = cr_q;

    run[1]  = aux_ctrl_q.run;
    unique case (aux_ctrl_q.src)
      AUX_PRESC: tick[1] = psc_tick[1];
      AUX_EXT:   tick[1] = aux_rise;
      AUX_CHAIN: tick[1] = wrap[0];   // latch flips on this same edge
      default:   tick[1] = 1'b0;
    endcase
    down[1]    = aux_ctrl_q.down ^ (aux_ctrl_q.ext_dir && pin_s[3]);
    load[1]    = wr_en_i && (addr_i == ADDR_W'(A_AUX_CNT));
    clr[1]     = cap_evt && aux_ctrl_q.clr_cap;
    rld_en[1]  = 1'b0;
    rld_val[1] = '0;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    dt_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .run_i(run[i]), .tick_i(tick[i]), .down_i(down[i]),
      .load_en_i(load[i]), .load_val_i(wdata_i),
      .clr_i(clr[i]),
      .reload_en_i(rld_en[i]), .reload_val_i(rld_val[i]),
      .cnt_o(cnt[i]), .wrap_o(wrap[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_ctrl_q <= '0;
      aux_ctrl_q  <= '0;
      cr_q        <= '0;
      tgl_o       <= 1'b0;
      core_irq_o  <= 1'b0;
      aux_irq_o   <= 1'b0;
      cap_irq_o   <= 1'b0;
    end else begin
      if (wr_core_ctl) core_ctrl_q <= core_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_aux_ctl)  aux_ctrl_q  <= aux_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (cap_evt)     cr_q <= cnt[1];      // capture beats software write
      else if (wr_cr)  cr_q <= wdata_i;
      if (wrap[0])     tgl_o <= !tgl_o;
      core_irq_o <= wrap[0];
      aux_irq_o  <= wrap[1];
      cap_irq_o  <= cap_evt;
    end
  end

  always_comb begin
    unique case (int'(addr_i))
      A_CORE_CTL: rdata_o = CNT_W'(core_ctrl_q);
      A_AUX_CTL:  rdata_o = CNT_W'(aux_ctrl_q);
      A_CORE_CNT: rdata_o = cnt[0];
      A_AUX_CNT:  rdata_o = cnt[1];
      A_CAPREL:   rdata_o = cr_q;
      default:    rdata_o = '0;
    endcase
  end

  AST_TGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[0] |=> (tgl_o != $past(tgl_o))); // R6
  AST_CAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cr_q == $past(cnt[1]))); // R10
  AST_CAP_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_irq_o); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_irq_o |=> !core_irq_o); // R3
  AST_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aux_ctrl_q.cap_en && !wr_cr) |=> $stable(cr_q)); // R11
endmodule

// File: tb/gp_dual_timer_bench.sv
module gp_dual_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic core_cnt_i = 0, core_dir_i = 0, aux_cnt_i = 0, aux_dir_i = 0, cap_i = 0;
  logic tgl_o, core_irq_o, aux_irq_o, cap_irq_o;

  int checks = 0, errors = 0;
  int core_irq_hi = 0, core_irq_rise = 0, cap_irq_hi = 0;
  logic core_irq_prev = 1'b0;

  always #2 clk_i = !clk_i;

  gp_dual_timer u_gp_dual_timer (.*);

  always @(negedge clk_i) if (rst_ni) begin
    if (core_irq_o) core_irq_hi++;
    if (core_irq_o && !core_irq_prev) core_irq_rise++;
    if (cap_irq_o) cap_irq_hi++;
    core_irq_prev = core_irq_o;
  end

  typedef struct packed {
    logic [15:0] init;
    logic        down;
    logic        xen;
    logic        pin;
    logic [7:0]  pulses;
    logic [15:0] exp;
    logic [1:0]  wraps;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0010, 1'b0, 1'b0, 1'b0, 8'd5, 16'h0015, 2'd0},
    '{16'hFFFE, 1'b0, 1'b0, 1'b0, 8'd3, 16'h0001, 2'd1},
    '{16'h0002, 1'b1, 1'b0, 1'b0, 8'd4, 16'hFFFE, 2'd1},
    '{16'h0100, 1'b0, 1'b1, 1'b1, 8'd3, 16'h00FD, 2'd0},
    '{16'h0005, 1'b1, 1'b1, 1'b1, 8'd2, 16'h0007, 2'd0},
    '{16'hFFFF, 1'b0, 1'b1, 1'b0, 8'd1, 16'h0000, 2'd1}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_core(input int n);
    for (int k = 0; k < n; k++) begin
      core_cnt_i = 1'b1; idle(3);
      core_cnt_i = 1'b0; idle(3);
    end
    idle(6);
  endtask

  task automatic measure(output int d);
    logic [15:0] a, b;
    int guard;
    rd(3'd2, a);
    guard = 0;
    do begin @(negedge clk_i); #1 b = rdata_o; guard++; end
    while (b == a && guard < 10000);
    a = b; d = 0;
    do begin @(negedge clk_i); #1 b = rdata_o; d++; end
    while (b == a && d < 10000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic        exp_tgl;
    int          wraps_tot, d;

    idle(3);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d after reset", a), v, 0);
    end
    chk("R1 outputs after reset", {tgl_o, core_irq_o, aux_irq_o, cap_irq_o}, 0);
    rst_ni = 1'b1;
    idle(2);

    // vector table: external source, direction, wrap, toggle latch
    exp_tgl = 1'b0; wraps_tot = 0;
    for (int i = 0; i < 6; i++) begin
      core_dir_i = VECS[i].pin;
      idle(5);
      wr(3'd2, VECS[i].init);
      wr(3'd0, 16'h0009 | {14'd0, VECS[i].down, 1'b0} | {13'd0, VECS[i].xen, 2'b0});
      pulse_core(int'(VECS[i].pulses));
      rd(3'd2, v);
      chk($sformatf("R3 R4 R5 vector %0d count", i), v, VECS[i].exp);
      exp_tgl ^= VECS[i].wraps[0];
      wraps_tot += int'(VECS[i].wraps);
      chk($sformatf("R6 vector %0d toggle", i), tgl_o, exp_tgl);
    end
    chk("R3 core irq cycles", core_irq_hi, wraps_tot);
    chk("R3 core irq single-cycle", core_irq_rise, wraps_tot);

    // R12: write lands on the same edge as an external count step
    wr(3'd2, 16'h1111);
    wr(3'd0, 16'h0009);
    @(negedge clk_i) core_cnt_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i) begin wr_en_i = 1'b1; addr_i = 3'd2; wdata_i = 16'h5000; end
    @(negedge clk_i) wr_en_i = 1'b0;
    rd(3'd2, v);
    chk("R12 write beats step", v, 16'h5000);
    core_cnt_i = 1'b0; idle(4);
    pulse_core(1);
    rd(3'd2, v);
    chk("R5 step after write", v, 16'h5001);

    // R7 + R8: chained aux, reload on wrap
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0011);
    wr(3'd4, 16'hFFFE);
    wr(3'd2, 16'hFFFF);
    wr(3'd0, 16'h0109);
    pulse_core(3);
    rd(3'd2, v);
    chk("R8 reload from capture/reload", v, 16'hFFFE);
    rd(3'd3, v);
    chk("R7 aux counts latch transitions", v, 16'h0002);
    chk("R6 two flips restore latch", tgl_o, exp_tgl);
    wr(3'd1, 16'h0018);

    // R2 prescaler intervals (n clamped to 2..12)
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0001);
    measure(d); chk("R2 n=0 clamps to 4 clocks", d, 4);
    wr(3'd0, 16'h0031);
    measure(d); chk("R2 n=3 gives 8 clocks", d, 8);
    wr(3'd0, 16'h00F1);
    measure(d); chk("R2 n=15 clamps to 4096 clocks", d, 4096);
    wr(3'd0, 16'h0000);
    rd(3'd2, v); idle(40);
    begin logic [15:0] v2; rd(3'd2, v2); chk("R2 stopped timer holds", v2, v); end

    // R9 capture on rising edge
    wr(3'd3, 16'h1234);
    wr(3'd1, 16'h0618);
    cap_i = 1'b1; idle(6);
    rd(3'd4, v);
    chk("R9 rising capture", v, 16'h1234);
    chk("R9 capture irq", cap_irq_hi, 1);
    wr(3'd3, 16'h2222);
    cap_i = 1'b0; idle(6);
    rd(3'd4, v);
    chk("R11 unselected falling edge ignored", v, 16'h1234);

    // R9 both edges with clear
    wr(3'd3, 16'h0042);
    wr(3'd1, 16'h1E18);
    cap_i = 1'b1; idle(6);
    rd(3'd4, v);
    chk("R9 both-edge capture", v, 16'h0042);
    rd(3'd3, v);
    chk("R9 clear on capture", v, 16'h0000);

    // R11 capture disabled
    wr(3'd3, 16'h0777);
    wr(3'd1, 16'h1C18);
    cap_i = 1'b0; idle(6);
    rd(3'd4, v);
    chk("R11 disabled capture keeps register", v, 16'h0042);
    rd(3'd3, v);
    chk("R11 disabled capture keeps aux", v, 16'h0777);
    chk("R11 no capture irq", cap_irq_hi, 2);

    // R10 capture versus software write in the same cycle
    wr(3'd3, 16'h0ABC);
    wr(3'd1, 16'h0618);
    @(negedge clk_i) cap_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i) begin wr_en_i = 1'b1; addr_i = 3'd4; wdata_i = 16'hBEEF; end
    @(negedge clk_i) wr_en_i = 1'b0;
    rd(3'd4, v);
    chk("R10 capture wins over write", v, 16'h0ABC);
    wr(3'd4, 16'h1357);
    rd(3'd4, v);
    chk("R10 plain write", v, 16'h1357);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    rd(3'd4, v);
    chk("R1 reset clears capture/reload", v, 0);
    rd(3'd0, v);
    chk("R1 reset clears core control", v, 0);

    summary();
    $finish;
  end
endmodule